// File: doc/BRIEF.md
# Interleaved Hardware-Thread Issue Scheduler

This block decides, on every clock, which hardware thread of a shared in-order pipeline may send an instruction to fetch. It holds a program counter for each thread and a per-thread "waiting on memory" block flag. It offers the fetch stage either a thread number with that thread's PC, or a bubble. The block supports three selection policies, chosen by a mode input. The first gives each thread a fixed slot in strict rotation and leaves a slot empty if its owner cannot go. The second picks the next eligible thread in circular order after the one that issued last. The third keeps one thread issuing until a cache miss is reported for it, and then moves to another thread in the same cycle. Switching threads costs no extra cycles.

The fetch side is a valid/ready stream. `issue_valid_o` offers a thread and PC, and `issue_ready_i` accepts it. The offer is recomputed every cycle from the current readiness, so it may change while it is not yet accepted. Nothing in the scheduler moves until the offer is taken: not the slot pointer, not any PC, and not the tag pipe entry. An accepted issue sends a thread tag with a valid bit into a shift pipe, one entry per downstream stage. Register reads and writebacks use that tag to select the right context.

Top module: `thread_issue_sched`

## Requirements
- R1: With mode 0 (fixed slots), the offered thread equals a slot pointer that steps by one, wrapping, on every cycle with `issue_ready_i` high, whether or not an instruction goes. If the slot's thread is not eligible, a bubble is offered and no other thread takes the slot.
- R2: With mode 1 (or 3), the offered thread is the first eligible one found searching circularly from the thread after the last accepted one. A bubble is offered only when no thread is eligible.
- R3: With mode 2 (switch on miss), the thread last accepted keeps issuing while it is eligible. `miss_vld_i` with `miss_tid_i` blocks that thread from the next cycle on. The next eligible thread in circular order is offered in that same next cycle, or a bubble if there is none. A thread is eligible when its `thr_rdy_i` bit is high and it is not blocked.
- R4: `miss_done_i[t]` clears the block of thread t from the next cycle on. A miss for the same thread in the same cycle takes precedence.
- R5: Each thread's PC resets to BOOT_BASE + t*BOOT_STEP. `issue_pc_o` is the offered thread's PC. An accepted issue adds INSN_BYTES to it. A `redir_vld_i[t]` pulse loads thread t's slice of `redir_pc_i` (bits t*PCW upward) instead, whether or not t issues.
- R6: While `issue_ready_i` is low, no pointer, PC or block state changes from issue, and tag stage 0 receives a bubble.
- R7: Tag stage k (stage 0 in bits [TW-1:0]) holds the valid bit and thread of the accepted issue from k+1 cycles earlier. The tag pipe shifts every cycle.
- R8: After reset, no tag stage is valid, all blocks are clear, and the slot and search pointer sits at thread 0.
- R9: In mode 0 with all threads ready and NSTG equal to NTHR, a thread issues again exactly when its previous instruction is in the last tag stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 fixed slots, 1/3 ready priority, 2 switch on miss |
| thr_rdy_i | input | NTHR | Per-thread readiness |
| miss_vld_i | input | 1 | Cache miss report (mode 2) |
| miss_tid_i | input | TW | Thread that missed |
| miss_done_i | input | NTHR | Per-thread miss completion |
| redir_vld_i | input | NTHR | Per-thread PC redirect strobe |
| redir_pc_i | input | NTHR*PCW | Redirect targets, thread t at bits t*PCW |
| issue_valid_o | output | 1 | Issue offer valid (low = bubble) |
| issue_ready_i | input | 1 | Fetch accepts the offer |
| issue_tid_o | output | TW | Offered thread |
| issue_pc_o | output | PCW | Offered thread's PC |
| stg_vld_o | output | NSTG | Tag valid per stage |
| stg_tid_o | output | NSTG*TW | Thread tag per stage, stage k at bits k*TW |

## Verification
The hardest situation to reach is a state where every thread is blocked behind a miss while its ready bit is still high. In that state mode 2 must offer a bubble, and only a later completion may release a thread. The stimulus first steers the switch-on-miss policy through three misses. It then sends a fourth miss and its completion for the same thread in the same cycle, which leaves all four blocked. One completion follows, and the bench checks which thread comes back and at which PC. Earlier redirects of both an issuing and a waiting thread make those PCs distinguishable.

// File: rtl/tis_pkg.sv
package tis_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED = 2'd0,
    MODE_PRIO  = 2'd1,
    MODE_SWAP  = 2'd2,
    MODE_ALT   = 2'd3
  } sched_mode_e;
endpackage

// File: rtl/tis_rr_pick.sv
module tis_rr_pick #(
  parameter int NTHR = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic [TW-1:0]   start_i,
  input  logic [NTHR-1:0] req_i,
  output logic            gnt_vld_o,
  output logic [TW-1:0]   gnt_idx_o
);
  // search downward so the nearest requester after start wins last
  always_comb begin
    int idx;
    gnt_vld_o = 1'b0;
    gnt_idx_o = '0;
    for (int k = NTHR - 1; k >= 0; k--) begin
      idx = (int'(start_i) + k) % NTHR;
      if (req_i[idx]) begin
        gnt_vld_o = 1'b1;
        gnt_idx_o = TW'(idx);
      end
    end
  end
endmodule

// File: rtl/tis_pc_bank.sv
module tis_pc_bank #(
  parameter int          NTHR       = 4,
  parameter int          PCW        = 32,
  parameter int unsigned BOOT_BASE  = 32'h1000,
  parameter int unsigned BOOT_STEP  = 32'h100,
  parameter int unsigned INSN_BYTES = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv_i,
  input  logic [TW-1:0]       adv_tid_i,
  input  logic [NTHR-1:0]     redir_vld_i,
  input  logic [NTHR*PCW-1:0] redir_pc_i,
  output logic [NTHR*PCW-1:0] pc_all_o
);
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    localparam logic [PCW-1:0] BOOT_PC = PCW'(BOOT_BASE + t * BOOT_STEP);
    logic [PCW-1:0] pc_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              pc_q <= BOOT_PC;
      else if (redir_vld_i[t])                 pc_q <= redir_pc_i[t*PCW +: PCW];
      else if (adv_i && adv_tid_i == TW'(t))   pc_q <= pc_q + PCW'(INSN_BYTES);
    end
    assign pc_all_o[t*PCW +: PCW] = pc_q;
  end
endmodule

// File: rtl/tis_tag_pipe.sv
module tis_tag_pipe #(
  parameter int NTHR = 4,
  parameter int NSTG = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld_i,
  input  logic [TW-1:0]      in_tid_i,
  output logic [NSTG-1:0]    vld_o,
  output logic [NSTG*TW-1:0] tid_o
);
  logic [NSTG-1:0]   vld_q;
  logic [NSTG*TW-1:0] tid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q[0] <= 1'b0;
    else        vld_q[0] <= in_vld_i;
    tid_q[TW-1:0] <= in_tid_i;
  end

  for (genvar s = 1; s < NSTG; s++) begin : g_stg
    always_ff @(posedge clk) begin
      if (!rst_n) vld_q[s] <= 1'b0;
      else        vld_q[s] <= vld_q[s-1];
      tid_q[s*TW +: TW] <= tid_q[(s-1)*TW +: TW];
    end
  end

  assign vld_o = vld_q;
  assign tid_o = tid_q;
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
  import tis_pkg::*;
#(
  parameter int          NTHR       = 4,
  parameter int          PCW        = 32,
  parameter int          NSTG       = 4,
  parameter int unsigned BOOT_BASE  = 32'h1000,
  parameter int unsigned BOOT_STEP  = 32'h100,
  parameter int unsigned INSN_BYTES = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic [NTHR-1:0]     thr_rdy_i,
  input  logic                miss_vld_i,
  input  logic [TW-1:0]       miss_tid_i,
  input  logic [NTHR-1:0]     miss_done_i,
  input  logic [NTHR-1:0]     redir_vld_i,
  input  logic [NTHR*PCW-1:0] redir_pc_i,
  output logic                issue_valid_o,
  input  logic                issue_ready_i,
  output logic [TW-1:0]       issue_tid_o,
  output logic [PCW-1:0]      issue_pc_o,
  output logic [NSTG-1:0]     stg_vld_o,
  output logic [NSTG*TW-1:0]  stg_tid_o
);
  sched_mode_e        mode;
  logic [TW-1:0]      ptr_q, ptr_d;
  logic [NTHR-1:0]    blk_q;
  logic [NTHR-1:0]    elig;
  logic               pick_vld;
  logic [TW-1:0]      pick_tid;
  logic               accept;
  logic [NTHR*PCW-1:0] pc_all;

  assign mode   = sched_mode_e'(mode_i);
  assign elig   = thr_rdy_i & ~blk_q;
  assign accept = issue_valid_o & issue_ready_i;

  function automatic logic [TW-1:0] step_tid(input logic [TW-1:0] x);
    return (int'(x) == NTHR - 1) ? '0 : x + TW'(1);
  endfunction

  tis_rr_pick #(.NTHR(NTHR)) u_pick (
    .start_i  (ptr_q),
    .req_i    (elig),
    .gnt_vld_o(pick_vld),
    .gnt_idx_o(pick_tid)
  );

  always_comb begin
    if (mode == MODE_FIXED) begin
      issue_valid_o = elig[ptr_q];
      issue_tid_o   = ptr_q;
    end else begin
      issue_valid_o = pick_vld;
      issue_tid_o   = pick_tid;
    end
  end

  // fixed: slot moves each offered cycle; priority: resume after winner;
  // swap-on-miss: stay on winner
  always_comb begin
    ptr_d = ptr_q;
    unique case (mode)
      MODE_FIXED: if (issue_ready_i) ptr_d = step_tid(ptr_q);
      MODE_SWAP:  if (accept)        ptr_d = issue_tid_o;
      default:    if (accept)        ptr_d = step_tid(issue_tid_o);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_blk
    always_ff @(posedge clk) begin
      if (!rst_n)
        blk_q[t] <= 1'b0;
      else if (miss_vld_i && mode == MODE_SWAP && miss_tid_i == TW'(t))
        blk_q[t] <= 1'b1;
      else if (miss_done_i[t])
        blk_q[t] <= 1'b0;
    end
  end

  tis_pc_bank #(
    .NTHR(NTHR), .PCW(PCW), .BOOT_BASE(BOOT_BASE),
    .BOOT_STEP(BOOT_STEP), .INSN_BYTES(INSN_BYTES)
  ) u_pcs (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (accept),
    .adv_tid_i  (issue_tid_o),
    .redir_vld_i(redir_vld_i),
    .redir_pc_i (redir_pc_i),
    .pc_all_o   (pc_all)
  );

  assign issue_pc_o = pc_all[int'(issue_tid_o)*PCW +: PCW];

  tis_tag_pipe #(.NTHR(NTHR), .NSTG(NSTG)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld_i(accept),
    .in_tid_i(issue_tid_o),
    .vld_o   (stg_vld_o),
    .tid_o   (stg_tid_o)
  );
endmodule

// File: rtl/tis_sched_chk.sv
module tis_sched_chk #(
  parameter int          NTHR       = 4,
  parameter int          PCW        = 32,
  parameter int          NSTG       = 4,
  parameter int unsigned INSN_BYTES = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode_i,
  input logic [NTHR-1:0]     thr_rdy_i,
  input logic                miss_vld_i,
  input logic [TW-1:0]       miss_tid_i,
  input logic [NTHR-1:0]     miss_done_i,
  input logic [NTHR-1:0]     redir_vld_i,
  input logic                issue_valid_o,
  input logic                issue_ready_i,
  input logic [TW-1:0]       issue_tid_o,
  input logic [PCW-1:0]      issue_pc_o,
  input logic [NSTG-1:0]     stg_vld_o,
  input logic [NSTG*TW-1:0]  stg_tid_o,
  input logic [NTHR-1:0]     blk_q
);
  logic armed;
  logic acc;
  logic fixed_m, prio_m, swap_m;
  logic [NTHR-1:0] elig;
  logic [NTHR-1:0] miss_mask;

  assign acc      = issue_valid_o & issue_ready_i;
  assign fixed_m  = (mode_i == 2'd0);
  assign swap_m   = (mode_i == 2'd2);
  assign prio_m   = !fixed_m && !swap_m;
  assign elig     = thr_rdy_i & ~blk_q;
  assign miss_mask = (miss_vld_i && swap_m) ? (NTHR'(1) << miss_tid_i) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  function automatic logic [TW-1:0] nxt(input logic [TW-1:0] x);
    return (int'(x) == NTHR - 1) ? '0 : x + TW'(1);
  endfunction

  always @(posedge clk)
    if (rst_n && !armed)
      assert_reset_clear_R8: assert (stg_vld_o == '0 && blk_q == '0);

  assert_fixed_rotate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fixed_m && acc && $past(fixed_m && acc)) |-> issue_tid_o == nxt($past(issue_tid_o)));

  assert_prio_no_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_m && (elig != '0)) |-> issue_valid_o);

  assert_only_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> (thr_rdy_i[issue_tid_o] && !blk_q[issue_tid_o]));

  assert_swap_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && swap_m && $past(swap_m && acc) && elig[$past(issue_tid_o)])
      |-> (issue_valid_o && issue_tid_o == $past(issue_tid_o)));

  assert_miss_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(miss_vld_i && swap_m)) |-> blk_q[$past(miss_tid_i)]);

  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((blk_q & $past(miss_done_i & ~miss_mask)) == '0));

  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(acc) && !$past(redir_vld_i[issue_tid_o]) && acc
      && issue_tid_o == $past(issue_tid_o))
      |-> issue_pc_o == $past(issue_pc_o) + PCW'(INSN_BYTES));

  assert_hold_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fixed_m && $past(fixed_m && !issue_ready_i)) |-> issue_tid_o == $past(issue_tid_o));

  assert_tag_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (stg_vld_o[0] == $past(acc)
               && (!stg_vld_o[0] || stg_tid_o[TW-1:0] == $past(issue_tid_o))));
endmodule

bind thread_issue_sched tis_sched_chk #(
  .NTHR(NTHR), .PCW(PCW), .NSTG(NSTG), .INSN_BYTES(INSN_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .thr_rdy_i(thr_rdy_i),
  .miss_vld_i(miss_vld_i), .miss_tid_i(miss_tid_i), .miss_done_i(miss_done_i),
  .redir_vld_i(redir_vld_i), .issue_valid_o(issue_valid_o),
  .issue_ready_i(issue_ready_i), .issue_tid_o(issue_tid_o),
  .issue_pc_o(issue_pc_o), .stg_vld_o(stg_vld_o), .stg_tid_o(stg_tid_o),
  .blk_q(blk_q)
);

// File: tb/test_thread_issue_sched.sv
`timescale 1ns/100ps
module test_thread_issue_sched;
  localparam int NTHR = 4;
  localparam int PCW  = 32;
  localparam int NSTG = 4;
  localparam int TW   = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [1:0]          mode_i = '0;
  logic [NTHR-1:0]     thr_rdy_i = '0;
  logic                miss_vld_i = 1'b0;
  logic [TW-1:0]       miss_tid_i = '0;
  logic [NTHR-1:0]     miss_done_i = '0;
  logic [NTHR-1:0]     redir_vld_i = '0;
  logic [NTHR*PCW-1:0] redir_pc_i = '0;
  logic                issue_valid_o;
  logic                issue_ready_i = 1'b0;
  logic [TW-1:0]       issue_tid_o;
  logic [PCW-1:0]      issue_pc_o;
  logic [NSTG-1:0]     stg_vld_o;
  logic [NSTG*TW-1:0]  stg_tid_o;

  always #2.5 clk = ~clk;

  thread_issue_sched i_thread_issue_sched (.*);

  typedef struct {
    logic        v;
    int          t;
    logic [31:0] pc;
    string       rq;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] model_pc [NTHR];
  int checks = 0;
  int errors = 0;

  task automatic chk(input logic ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue what fetch must see
  task automatic drive(input logic [1:0] md, input logic [3:0] rdy, input logic ir,
                       input logic mv, input int mt, input logic [3:0] done,
                       input logic [3:0] rv, input logic [31:0] rpc,
                       input logic ev, input int et, input string rq);
    exp_t e;
    @(negedge clk);
    mode_i = md; thr_rdy_i = rdy; issue_ready_i = ir;
    miss_vld_i = mv; miss_tid_i = TW'(mt); miss_done_i = done;
    redir_vld_i = rv; redir_pc_i = {NTHR{rpc}};
    e.v = ev; e.t = et; e.pc = model_pc[et]; e.rq = rq;
    sb.push_back(e);
    if (ev && ir) model_pc[et] = model_pc[et] + 32'd4;
    for (int t = 0; t < NTHR; t++) if (rv[t]) model_pc[t] = rpc;
  endtask

  // monitor: compare the offer mid-cycle
  always @(negedge clk) begin
    exp_t e;
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      chk(issue_valid_o == e.v, {e.rq, " valid"}, issue_valid_o, e.v);
      if (e.v) begin
        chk(int'(issue_tid_o) == e.t, {e.rq, " tid"}, issue_tid_o, e.t);
        chk(issue_pc_o == e.pc, {e.rq, " pc"}, issue_pc_o, e.pc);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < NTHR; t++) model_pc[t] = 32'h1000 + 32'h100 * t;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R8: idle after reset, nothing ready, no offer accepted
    drive(0, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 0, "R8 reset bubble");
    #1.5 chk(stg_vld_o == '0, "R8 stages empty", stg_vld_o, 0);

    // R1 R5 R7 R9: fixed rotation with everyone ready
    for (int i = 0; i < 8; i++) begin
      drive(0, 4'b1111, 1, 0, 0, 0, 0, 0, 1, i % 4, "R1 rotation");
      if (i == 4) begin
        #1.5;
        chk(stg_vld_o[3] && stg_tid_o[7:6] == 2'd0, "R9 same thread in last stage", stg_tid_o[7:6], 0);
        chk(stg_vld_o[0] && stg_tid_o[1:0] == 2'd3, "R7 stage0 holds prior issue", stg_tid_o[1:0], 3);
      end
    end

    // R1: thread 2 not ready leaves its slot empty
    drive(0, 4'b1011, 1, 0, 0, 0, 0, 0, 1, 0, "R1 slot0");
    drive(0, 4'b1011, 1, 0, 0, 0, 0, 0, 1, 1, "R1 slot1");
    drive(0, 4'b1011, 1, 0, 0, 0, 0, 0, 0, 2, "R1 slot2 bubble");
    drive(0, 4'b1011, 1, 0, 0, 0, 0, 0, 1, 3, "R1 slot3");

    // R6: back-pressure holds slot and PC
    drive(0, 4'b1111, 0, 0, 0, 0, 0, 0, 1, 0, "R6 offer held");
    drive(0, 4'b1111, 1, 0, 0, 0, 0, 0, 1, 0, "R6 same offer retaken");
    #1.5 chk(stg_vld_o[0] == 1'b0, "R6 stage0 bubble", stg_vld_o[0], 0);

    // R2: priority from thread after last winner
    drive(1, 4'b0101, 1, 0, 0, 0, 0, 0, 1, 2, "R2 search from 1");
    drive(1, 4'b0101, 1, 0, 0, 0, 0, 0, 1, 0, "R2 wrap to 0");
    drive(1, 4'b0101, 1, 0, 0, 0, 0, 0, 1, 2, "R2 back to 2");
    drive(1, 4'b0000, 1, 0, 0, 0, 0, 0, 0, 0, "R2 none ready");
    drive(1, 4'b1000, 1, 0, 0, 0, 0, 0, 1, 3, "R2 lone thread");

    // R3 R4 R5: switch on miss
    drive(2, 4'b1111, 1, 0, 0, 0, 0, 0, 1, 0, "R3 start t0");
    drive(2, 4'b1111, 1, 0, 0, 0, 0, 0, 1, 0, "R3 t0 sticks");
    drive(2, 4'b1111, 1, 1, 0, 0, 0, 0, 1, 0, "R3 t0 misses");
    drive(2, 4'b1111, 1, 0, 0, 0, 0, 0, 1, 1, "R3 swap to t1");
    drive(2, 4'b1111, 1, 0, 0, 0, 4'b1010, 32'h2000, 1, 1, "R5 redirect t1 t3");
    drive(2, 4'b1111, 1, 1, 1, 0, 0, 0, 1, 1, "R5 t1 at target");
    drive(2, 4'b1111, 1, 1, 2, 0, 0, 0, 1, 2, "R3 swap to t2");
    drive(2, 4'b1111, 1, 1, 3, 4'b1000, 0, 0, 1, 3, "R5 waiting t3 redirected");
    drive(2, 4'b1111, 1, 0, 0, 0, 0, 0, 0, 0, "R4 miss beats done, all blocked");
    drive(2, 4'b1111, 1, 0, 0, 4'b0001, 0, 0, 0, 0, "R3 bubble while blocked");
    drive(2, 4'b1111, 1, 0, 0, 0, 0, 0, 1, 0, "R4 t0 released");
    drive(2, 4'b1111, 1, 0, 0, 4'b1000, 0, 0, 1, 0, "R4 t0 continues");
    drive(2, 4'b1110, 1, 0, 0, 0, 0, 0, 1, 3, "R4 t3 released");

    @(negedge clk); @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule